// File: doc/BRIEF.md
# Byte Lane Mask, Extract and Insert Unit

This unit reshapes 64-bit operands one byte lane at a time, so that data lying across a quadword boundary can be split, merged and cleaned up in registers. From an operand `opA`, a second operand `opB` (a register value or a literal) and a 7-bit function code, it can clear a field of bytes, pull a field out to the low end, move a field into position, clear bytes selected by a byte mask, or shift the whole word.

Field operations take their byte offset from `opB[2:0]` and move data by eight bits per offset step. Fields are 1, 2, 4 or 8 bytes wide. The "low" variants place the field at the offset. The "high" variants deal with the part that spills past the top of the quadword, and they use the complementary distance of 64 minus eight times the offset. An offset of zero is a special case for these variants. One operation is accepted per cycle when `inValid` is high. Its result appears, registered, on the next cycle together with `outValid`.

Top module: `byte_lane_unit`

## Requirements
- R1: While `rstN` is low, `outValid`, `illegalCode` and `result` are all 0.
- R2: `outValid` is high in exactly the cycle after a cycle with `inValid` high. When `inValid` is low, `result` keeps its previous value.
- R3: The mask-low codes 0x02, 0x12, 0x22 and 0x32 return `opA` with a field of 1, 2, 4 or 8 bytes cleared. The field starts at byte `opB[2:0]`, and bytes beyond byte 7 are not affected.
- R4: The mask-high codes 0x52, 0x62 and 0x72 use a field of n = 2, 4 or 8 bytes. With offset zero they return `opA` unchanged. Otherwise they clear byte j of `opA` for every j below n + offset − 8.
- R5: The extract-low codes 0x06, 0x16, 0x26 and 0x36 shift `opA` right by 8×offset bits, filling with zeros, and keep the low 8, 16, 32 or 64 bits.
- R6: The extract-high codes 0x5a, 0x6a and 0x7a shift `opA` left by (64 − 8×offset) mod 64 bits and keep the low 16, 32 or 64 bits. An offset of zero therefore gives no shift.
- R7: The insert-low codes 0x0b, 0x1b, 0x2b and 0x3b take the low 1, 2, 4 or 8 bytes of `opA` and shift them left by 8×offset bits. Bits moved past bit 63 are lost.
- R8: The insert-high codes 0x57, 0x67 and 0x77 return 0 when the offset is zero. Otherwise they take the low 2, 4 or 8 bytes of `opA` and shift them right by 64 − 8×offset bits.
- R9: Code 0x30 clears byte i of `opA` wherever `opB[i]` is 1. Code 0x31 clears byte i wherever `opB[i]` is 0.
- R10: Codes 0x39, 0x34 and 0x3c shift `opA` by `opB[5:0]` bits. 0x39 is a left shift and 0x34 a logical right shift, both filling with zeros. 0x3c is an arithmetic right shift that replicates bit 63.
- R11: Any other code raises `illegalCode` with `outValid` and gives a `result` of 0. Every listed code gives `illegalCode` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operation strobe |
| funcCode | input | 7 | Function code |
| opA | input | 64 | Data operand |
| opB | input | 64 | Offset, shift amount, byte select or register operand |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| result | output | 64 | Registered result |
| illegalCode | output | 1 | The accepted code was not a defined operation |

## Verification
The assertions assume that `inValid`, `funcCode`, `opA` and `opB` are stable and known on every sampled edge after reset. They also compare offset-zero corner results against the operands of the cycle before, which assumes one operation per strobe with no back-pressure. The bench changes inputs only on falling edges. It draws codes mostly from the defined set, with a share of fully random 7-bit codes, so the illegal path is also reached. Directed runs at offsets 0 and 7 and at byte selects 0x00 and 0xFF cover the edges that random draws seldom reach.

// File: rtl/blu_pkg.sv
package blu_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_MSKL, OP_MSKH, OP_EXTL, OP_EXTH, OP_INSL, OP_INSH,
    OP_ZAP, OP_ZAPNOT, OP_SLL, OP_SRL, OP_SRA
  } op_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       load;
    op_e        op;
    logic [1:0] sizeSel;  // field width = 1 << sizeSel bytes
  } ctrl_t;
endpackage

// File: rtl/blu_ctrl.sv
module blu_ctrl
  import blu_pkg::*;
#(
  parameter int FUNC_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [FUNC_W-1:0] funcCode,
  output ctrl_t             ctrl,
  output logic              outValid,
  output logic              illegalCode
);
  op_e  opDec;
  logic [1:0] sizeDec;

  always_comb begin
    opDec   = OP_NONE;
    sizeDec = funcCode[5:4];
    case (funcCode)
      7'h02, 7'h12, 7'h22, 7'h32: opDec = OP_MSKL;
      7'h52, 7'h62, 7'h72:        opDec = OP_MSKH;
      7'h06, 7'h16, 7'h26, 7'h36: opDec = OP_EXTL;
      7'h5a, 7'h6a, 7'h7a:        opDec = OP_EXTH;
      7'h0b, 7'h1b, 7'h2b, 7'h3b: opDec = OP_INSL;
      7'h57, 7'h67, 7'h77:        opDec = OP_INSH;
      7'h30:                      opDec = OP_ZAP;
      7'h31:                      opDec = OP_ZAPNOT;
      7'h39:                      opDec = OP_SLL;
      7'h34:                      opDec = OP_SRL;
      7'h3c:                      opDec = OP_SRA;
      default:                    opDec = OP_NONE;
    endcase
  end

  assign ctrl.load    = inValid;
  assign ctrl.op      = opDec;
  assign ctrl.sizeSel = sizeDec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid    <= 1'b0;
      illegalCode <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) illegalCode <= (opDec == OP_NONE);
      else         illegalCode <= 1'b0;
    end
  end
endmodule

// File: rtl/blu_datapath.sv
module blu_datapath
  import blu_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] result
);
  localparam int BYTES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(BYTES);
  localparam int SHAMT_W = $clog2(DATA_W);
  localparam logic [SHAMT_W:0] FULL_SH = SHAMT_W'(0) + (SHAMT_W+1)'(DATA_W);

  logic [OFF_W-1:0]   offset;
  logic [SHAMT_W-1:0] loSh;
  logic [SHAMT_W:0]   hiSh;
  logic [SHAMT_W-1:0] wrapSh;
  logic [SHAMT_W-1:0] bitSh;
  logic [DATA_W-1:0]  fieldMask;
  logic [DATA_W-1:0]  byteSel;
  logic [DATA_W-1:0]  nextVal;
  logic               offZero;

  assign offset  = opB[OFF_W-1:0];
  assign offZero = (offset == '0);
  assign loSh    = {offset, 3'b000};
  assign hiSh    = FULL_SH - {1'b0, loSh};
  assign wrapSh  = hiSh[SHAMT_W-1:0];
  assign bitSh   = opB[SHAMT_W-1:0];

  // per-byte expansion of field width and zap select
  for (genvar j = 0; j < BYTES; j++) begin : g_lane
    assign fieldMask[j*8 +: 8] = {8{(j < (1 << ctrl.sizeSel))}};
    assign byteSel[j*8 +: 8]   = {8{opB[j]}};
  end

  always_comb begin
    nextVal = '0;
    unique case (ctrl.op)
      OP_MSKL:   nextVal = opA & ~(fieldMask << loSh);
      OP_MSKH:   nextVal = offZero ? opA : (opA & ~(fieldMask >> hiSh));
      OP_EXTL:   nextVal = (opA >> loSh) & fieldMask;
      OP_EXTH:   nextVal = (opA << wrapSh) & fieldMask;
      OP_INSL:   nextVal = (opA & fieldMask) << loSh;
      OP_INSH:   nextVal = offZero ? '0 : ((opA & fieldMask) >> hiSh);
      OP_ZAP:    nextVal = opA & ~byteSel;
      OP_ZAPNOT: nextVal = opA & byteSel;
      OP_SLL:    nextVal = opA << bitSh;
      OP_SRL:    nextVal = opA >> bitSh;
      OP_SRA:    nextVal = DATA_W'($signed(opA) >>> bitSh);
      default:   nextVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          result <= '0;
    else if (ctrl.load) result <= nextVal;
  end
endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
  import blu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [FUNC_W-1:0] funcCode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegalCode
);
  ctrl_t ctrl;

  blu_ctrl #(.FUNC_W(FUNC_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .funcCode(funcCode),
    .ctrl(ctrl), .outValid(outValid), .illegalCode(illegalCode)
  );

  blu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB),
    .result(result)
  );
endmodule

// File: rtl/blu_checker.sv
module blu_checker #(
  parameter int DATA_W = 64,
  parameter int FUNC_W = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [FUNC_W-1:0] funcCode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              outValid,
  input logic [DATA_W-1:0] result,
  input logic              illegalCode
);
  logic isMskh, isInsh;
  assign isMskh = (funcCode == 7'h52) || (funcCode == 7'h62) || (funcCode == 7'h72);
  assign isInsh = (funcCode == 7'h57) || (funcCode == 7'h67) || (funcCode == 7'h77);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid); // R2
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result)); // R2
  AST_MSKH_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isMskh && opB[2:0] == 3'd0) |=> (result == $past(opA))); // R4
  AST_INSH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && isInsh && opB[2:0] == 3'd0) |=> (result == '0)); // R8
  AST_ZAP_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && funcCode == 7'h30 && opB[7:0] == 8'hFF) |=> (result == '0)); // R9
  AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    illegalCode |-> (outValid && result == '0)); // R11
endmodule

bind byte_lane_unit blu_checker #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .funcCode(funcCode),
  .opA(opA), .opB(opB), .outValid(outValid), .result(result),
  .illegalCode(illegalCode)
);

// File: tb/byte_lane_unit_bench.sv
module byte_lane_unit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [6:0]  funcCode = '0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid;
  logic [63:0] result;
  logic        illegalCode;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  byte_lane_unit u_byte_lane_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .funcCode(funcCode),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result),
    .illegalCode(illegalCode)
  );

  logic [6:0] legal [26] = '{7'h02, 7'h12, 7'h22, 7'h32, 7'h52, 7'h62, 7'h72,
                             7'h06, 7'h16, 7'h26, 7'h36, 7'h5a, 7'h6a, 7'h7a,
                             7'h0b, 7'h1b, 7'h2b, 7'h3b, 7'h57, 7'h67, 7'h77,
                             7'h30, 7'h31, 7'h39, 7'h34, 7'h3c};

  function automatic bit isLegal(input logic [6:0] c);
    for (int k = 0; k < 26; k++) if (legal[k] == c) return 1;
    return 0;
  endfunction

  function automatic string tagOf(input logic [6:0] c);
    if (!isLegal(c)) return "R11";
    case (c)
      7'h02, 7'h12, 7'h22, 7'h32: return "R3";
      7'h52, 7'h62, 7'h72:        return "R4";
      7'h06, 7'h16, 7'h26, 7'h36: return "R5";
      7'h5a, 7'h6a, 7'h7a:        return "R6";
      7'h0b, 7'h1b, 7'h2b, 7'h3b: return "R7";
      7'h57, 7'h67, 7'h77:        return "R8";
      7'h30, 7'h31:               return "R9";
      default:                    return "R10";
    endcase
  endfunction

  // byte-lane reference model
  function automatic logic [63:0] refModel(input logic [6:0] c,
                                           input logic [63:0] a,
                                           input logic [63:0] b);
    logic [63:0] r;
    int off, n, s, src;
    r = '0;
    off = int'(b[2:0]);
    n = 1 << c[5:4];
    if (!isLegal(c)) return '0;
    case (tagOf(c))
      "R3": begin
        r = a;
        for (int j = 0; j < 8; j++) if (j >= off && j < off + n) r[j*8 +: 8] = 8'h00;
      end
      "R4": begin
        r = a;
        if (off != 0)
          for (int j = 0; j < 8; j++) if (j < n + off - 8) r[j*8 +: 8] = 8'h00;
      end
      "R5": for (int j = 0; j < n; j++) if (j + off < 8) r[j*8 +: 8] = a[(j+off)*8 +: 8];
      "R6": begin
        s = (8 - off) % 8;
        for (int j = 0; j < n; j++) if (j >= s) r[j*8 +: 8] = a[(j-s)*8 +: 8];
      end
      "R7": for (int j = 0; j < 8; j++) begin
        src = j - off;
        if (src >= 0 && src < n) r[j*8 +: 8] = a[src*8 +: 8];
      end
      "R8": if (off != 0)
        for (int j = 0; j < 8; j++) begin
          src = j + 8 - off;
          if (src < n) r[j*8 +: 8] = a[src*8 +: 8];
        end
      "R9": for (int j = 0; j < 8; j++)
        r[j*8 +: 8] = ((c == 7'h30) ? b[j] : !b[j]) ? 8'h00 : a[j*8 +: 8];
      default: begin
        s = int'(b[5:0]);
        for (int i = 0; i < 64; i++) begin
          if (c == 7'h39)      r[i] = (i - s >= 0) ? a[i-s] : 1'b0;
          else if (c == 7'h34) r[i] = (i + s < 64) ? a[i+s] : 1'b0;
          else                 r[i] = (i + s < 64) ? a[i+s] : a[63];
        end
      end
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(input logic [6:0] c, input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    inValid = 1'b1; funcCode = c; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
    check(tagOf(c), "result", result, refModel(c, a, b));
    check("R11", "illegal flag", {63'd0, illegalCode}, {63'd0, !isLegal(c)});
    check("R2", "valid after strobe", {63'd0, outValid}, 64'd1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<100000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", "reset result", result, 64'd0);
    check("R1", "reset valid", {63'd0, outValid}, 64'd0);
    check("R1", "reset illegal", {63'd0, illegalCode}, 64'd0);
    rstN = 1'b1;

    // directed corners: every legal code at offsets 0 and 7
    for (int k = 0; k < 26; k++) begin
      runOp(legal[k], 64'hF1E2_D3C4_B5A6_9788, 64'h0);
      runOp(legal[k], 64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FF07);
      runOp(legal[k], 64'h8000_0000_0000_0001, 64'h3F);
    end
    runOp(7'h30, 64'hDEAD_BEEF_CAFE_F00D, 64'hFF);  // R9 all bytes cleared
    runOp(7'h31, 64'hDEAD_BEEF_CAFE_F00D, 64'h00);  // R9 zapnot clears all
    runOp(7'h3c, 64'h8000_0000_0000_0000, 64'd63);  // R10 arithmetic fill
    runOp(7'h00, 64'hFFFF, 64'h1);                  // R11
    runOp(7'h7f, 64'hFFFF, 64'h1);                  // R11

    // R2: idle cycles hold result and drop valid
    runOp(7'h36, 64'h1122_3344_5566_7788, 64'h3);
    held = result;
    @(negedge clk);
    opA = 64'hFFFF_FFFF_FFFF_FFFF; funcCode = 7'h39; opB = 64'h5;
    @(negedge clk);
    check("R2", "result held while idle", result, held);
    check("R2", "valid low while idle", {63'd0, outValid}, 64'd0);

    // random
    for (int it = 0; it < 600; it++) begin
      logic [6:0] c;
      if ($urandom_range(0, 4) == 0) c = 7'($urandom);
      else c = legal[$urandom_range(0, 25)];
      runOp(c, {$urandom, $urandom}, {$urandom, $urandom});
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule